// File: doc/BRIEF.md
# Machine Timer Interrupt Unit

This block keeps a free-running 64-bit machine time count and a 64-bit alarm value, and turns their comparison into the machine timer interrupt. Each clock in which the tick input is high adds a caller-supplied 32-bit step to the count. A carry out of the low word ripples into the high word. The count can therefore track microseconds, cycles or any other unit the surrounding logic chooses.

Software reaches the four 32-bit words (count low, count high, alarm low, alarm high) through a small request/response port. The pending flag is derived afresh every cycle from the registered count and alarm. It wakes a core parked in wait-for-interrupt, and is combined with the enable bits from the core to decide whether the interrupt is taken. The request side is valid/ready, with ready always high, so a request is accepted in the cycle its valid is seen. The response side has no ready: the consumer must take a read response in the cycle it is presented.

Top module: `mtimer_unit`

## Requirements
- R1: After reset the count and alarm words all read as zero, no response is pending, and the pending, wake and take outputs are low.
- R2: In a cycle with tick high and no write to a count word, the low count word grows by the step input modulo 2^32. With tick low the count holds.
- R3: When that addition carries out of the low word, the high count word grows by one in the same cycle.
- R4: A write to either count word replaces that cycle's increment. The written word takes the write data, the other count word keeps its value, and the new value is visible from the next cycle on.
- R5: The alarm low and alarm high words can be written and read back, with a one-cycle write latency.
- R6: Pending is high exactly when the 64-bit count is strictly greater than the 64-bit alarm and the alarm is not zero. Equality does not raise it.
- R7: An alarm of all zeros keeps pending low whatever the count holds.
- R8: Pending is not latched. It falls in the cycle after a write makes the condition false.
- R9: The wake output equals pending.
- R10: Take is high only when pending, bit 7 of the enable input and bit 3 of the status input are all set. While take is high, cause reads 0x80000007. While take is low, cause reads zero. The trap value output is always zero.
- R11: Word map relative to the base address 0x10000000: offset 0x0 count low, 0x4 count high, 0x8 alarm low, 0xC alarm high. A request whose address lies outside 0x10000000 up to but excluding 0x12000000, or that does not match one of those four words, writes nothing and reads back zero. Each read request gets exactly one response in the next cycle; writes get none.
- R12: The pending vector output carries pending in bit 7 and zero in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Advance the count this cycle |
| tick_incr_i | input | 32 | Step added on a tick |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Request ready, always high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte address of the request |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read response valid, one cycle after the read |
| rsp_rdata_o | output | 32 | Read response data |
| int_en_i | input | 32 | Interrupt-enable word; bit 7 enables the timer |
| status_i | input | 32 | Status word; bit 3 is the global enable |
| pend_vec_o | output | 32 | Interrupt-pending word; bit 7 is the timer |
| wake_o | output | 1 | Release a wait-for-interrupt stall |
| take_o | output | 1 | Timer interrupt taken |
| cause_o | output | 32 | Cause code for a taken interrupt |
| tval_o | output | 32 | Trap value for a taken interrupt |

## Verification
A wrong count shows up in the next read response: a dropped or duplicated carry moves the high word by one, and a write that does not replace the increment leaves the low word off by exactly the step. A fault in the comparison appears at pend_vec_o, wake_o and take_o in the cycle right after the write that moves the count or alarm across the boundary. For that reason the bench probes the equal, one-above and zero-alarm points one cycle apart. A decode fault appears as a stray response or as a changed word on the next readback.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  typedef enum logic [1:0] {
    MT_TIME_LO = 2'd0,
    MT_TIME_HI = 2'd1,
    MT_CMP_LO  = 2'd2,
    MT_CMP_HI  = 2'd3
  } mt_word_e;

  localparam int unsigned MT_NUM_WORDS = 4;
  localparam int unsigned MT_IRQ_BIT   = 7;
  localparam int unsigned MT_GIE_BIT   = 3;
endpackage

// File: rtl/mt_bus_port.sv
module mt_bus_port #(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned AW       = 32,
  parameter logic [31:0] BASE     = 32'h1000_0000,
  parameter logic [31:0] WIN_LO   = 32'h1000_0000,
  parameter logic [31:0] WIN_HI   = 32'h1200_0000
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       req_valid_i,
  input  logic                                       req_write_i,
  input  logic [AW-1:0]                              req_addr_i,
  input  logic [mtimer_pkg::MT_NUM_WORDS-1:0][XLEN-1:0] words_i,
  output logic [mtimer_pkg::MT_NUM_WORDS-1:0]        wr_stb_o,
  output logic                                       rsp_valid_o,
  output logic [XLEN-1:0]                            rsp_rdata_o
);
  import mtimer_pkg::*;

  localparam int unsigned IDX_W  = $clog2(MT_NUM_WORDS);
  localparam int unsigned LSB    = $clog2(XLEN / 8);
  localparam logic [AW-1:0] WORD_MASK = AW'(((MT_NUM_WORDS - 1) << LSB) | ((1 << LSB) - 1));

  logic             in_win;
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             rsp_valid_q;
  logic [XLEN-1:0]  rsp_rdata_q;

  assign in_win = (req_addr_i >= AW'(WIN_LO)) && (req_addr_i < AW'(WIN_HI));
  assign hit    = in_win
               && ((req_addr_i & ~WORD_MASK) == AW'(BASE))
               && (req_addr_i[LSB-1:0] == '0);
  assign idx    = req_addr_i[LSB +: IDX_W];

  for (genvar w = 0; w < MT_NUM_WORDS; w++) begin : g_stb
    assign wr_stb_o[w] = req_valid_i && req_write_i && hit && (idx == IDX_W'(w));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid_i && !req_write_i;
      if (req_valid_i && !req_write_i) begin
        rsp_rdata_q <= hit ? words_i[idx] : '0;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(req_valid_i && !req_write_i)); // R11
  AST_READ_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_write_i) |=> rsp_valid_o); // R11
endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic [XLEN-1:0] incr_i,
  input  logic            wr_lo_i,
  input  logic            wr_hi_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] lo_o,
  output logic [XLEN-1:0] hi_o
);
  logic [XLEN-1:0] lo_q, hi_q;
  logic [XLEN:0]   sum;
  logic            any_wr;

  assign sum    = {1'b0, lo_q} + {1'b0, incr_i};
  assign any_wr = wr_lo_i || wr_hi_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (any_wr) begin
      if (wr_lo_i) lo_q <= wdata_i;
      if (wr_hi_i) hi_q <= wdata_i;
    end else if (tick_i) begin
      lo_q <= sum[XLEN-1:0];
      hi_q <= hi_q + XLEN'(sum[XLEN]);
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !any_wr) |=> lo_o == $past(lo_o + incr_i)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !any_wr) |=> ($stable(lo_o) && $stable(hi_o))); // R2
  AST_CARRY_RIPPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !any_wr && (lo_o > ~incr_i)) |=> hi_o == $past(hi_o + 1'b1)); // R3
  AST_WRITE_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_i && !wr_lo_i) |=> ($stable(lo_o) && hi_o == $past(wdata_i))); // R4
endmodule

// File: rtl/mt_compare.sv
module mt_compare #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      wr_stb_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] time_lo_i,
  input  logic [XLEN-1:0] time_hi_i,
  output logic [1:0][XLEN-1:0] cmp_o,
  output logic            pend_o
);
  localparam int unsigned TW = 2 * XLEN;

  logic [1:0][XLEN-1:0] cmp_q;
  logic [TW-1:0]        time_full;
  logic [TW-1:0]        cmp_full;

  for (genvar w = 0; w < 2; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q[w] <= '0;
      end else if (wr_stb_i[w]) begin
        cmp_q[w] <= wdata_i;
      end
    end
  end

  assign time_full = {time_hi_i, time_lo_i};
  assign cmp_full  = {cmp_q[1], cmp_q[0]};
  assign pend_o    = (time_full > cmp_full) && (cmp_full != '0);
  assign cmp_o     = cmp_q;

  AST_CMP_WR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_i[0] |=> cmp_o[0] == $past(wdata_i)); // R5
endmodule

// File: rtl/mt_irq.sv
module mt_irq #(
  parameter int unsigned XLEN = 32
) (
  input  logic            pend_i,
  input  logic [XLEN-1:0] int_en_i,
  input  logic [XLEN-1:0] status_i,
  output logic [XLEN-1:0] pend_vec_o,
  output logic            take_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] tval_o
);
  import mtimer_pkg::*;

  localparam logic [XLEN-1:0] CAUSE_TIMER = {1'b1, {(XLEN-1){1'b0}}} | XLEN'(MT_IRQ_BIT);

  assign pend_vec_o = XLEN'(pend_i) << MT_IRQ_BIT;
  assign take_o     = pend_i && int_en_i[MT_IRQ_BIT] && status_i[MT_GIE_BIT];
  assign cause_o    = take_o ? CAUSE_TIMER : '0;
  assign tval_o     = '0;
endmodule

// File: rtl/mtimer_unit.sv
module mtimer_unit #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned AW     = 32,
  parameter logic [31:0] BASE   = 32'h1000_0000,
  parameter logic [31:0] WIN_LO = 32'h1000_0000,
  parameter logic [31:0] WIN_HI = 32'h1200_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic [XLEN-1:0] tick_incr_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_write_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [XLEN-1:0] req_wdata_i,
  output logic            rsp_valid_o,
  output logic [XLEN-1:0] rsp_rdata_o,
  input  logic [XLEN-1:0] int_en_i,
  input  logic [XLEN-1:0] status_i,
  output logic [XLEN-1:0] pend_vec_o,
  output logic            wake_o,
  output logic            take_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] tval_o
);
  import mtimer_pkg::*;

  logic [MT_NUM_WORDS-1:0][XLEN-1:0] words;
  logic [MT_NUM_WORDS-1:0]           wr_stb;
  logic [XLEN-1:0]                   time_lo, time_hi;
  logic [1:0][XLEN-1:0]              cmp_w;
  logic                              pend;

  assign req_ready_o = 1'b1;

  mt_bus_port #(.XLEN(XLEN), .AW(AW), .BASE(BASE), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .words_i     (words),
    .wr_stb_o    (wr_stb),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  mt_counter #(.XLEN(XLEN)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .incr_i  (tick_incr_i),
    .wr_lo_i (wr_stb[MT_TIME_LO]),
    .wr_hi_i (wr_stb[MT_TIME_HI]),
    .wdata_i (req_wdata_i),
    .lo_o    (time_lo),
    .hi_o    (time_hi)
  );

  mt_compare #(.XLEN(XLEN)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb_i  ({wr_stb[MT_CMP_HI], wr_stb[MT_CMP_LO]}),
    .wdata_i   (req_wdata_i),
    .time_lo_i (time_lo),
    .time_hi_i (time_hi),
    .cmp_o     (cmp_w),
    .pend_o    (pend)
  );

  mt_irq #(.XLEN(XLEN)) u_irq (
    .pend_i     (pend),
    .int_en_i   (int_en_i),
    .status_i   (status_i),
    .pend_vec_o (pend_vec_o),
    .take_o     (take_o),
    .cause_o    (cause_o),
    .tval_o     (tval_o)
  );

  assign words[MT_TIME_LO] = time_lo;
  assign words[MT_TIME_HI] = time_hi;
  assign words[MT_CMP_LO]  = cmp_w[0];
  assign words[MT_CMP_HI]  = cmp_w[1];
  assign wake_o            = pend;

  AST_ZERO_ALARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_w == '0) |-> !pend_vec_o[MT_IRQ_BIT]); // R7
  AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (wake_o && int_en_i[MT_IRQ_BIT] && status_i[MT_GIE_BIT])); // R10
  AST_EQUAL_NOT_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ({time_hi, time_lo} == {cmp_w[1], cmp_w[0]}) |-> !wake_o); // R6
endmodule

// File: tb/mtimer_unit_bench.sv
module mtimer_unit_bench;
  localparam logic [31:0] B = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [31:0] tick_incr_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic [31:0] int_en_i = '0;
  logic [31:0] status_i = '0;
  logic [31:0] pend_vec_o;
  logic        wake_o;
  logic        take_o;
  logic [31:0] cause_o;
  logic [31:0] tval_o;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  mtimer_unit u_mtimer_unit (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .tick_incr_i(tick_incr_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o), .int_en_i(int_en_i), .status_i(status_i),
    .pend_vec_o(pend_vec_o), .wake_o(wake_o), .take_o(take_o), .cause_o(cause_o),
    .tval_o(tval_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = a; req_wdata_i = d;
    @(negedge clk);
    req_valid_i = 1'b0; req_write_i = 1'b0;
  endtask

  task automatic bus_read(input logic [31:0] a, input logic [31:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic do_tick(input int n, input logic [31:0] inc);
    @(negedge clk);
    tick_i = 1'b1; tick_incr_i = inc;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic chk_irq(input string req, input logic p);
    #1;
    chk(req, pend_vec_o, p ? 32'h80 : 32'h0);
    chk(req, {31'b0, wake_o}, {31'b0, p});
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid_o) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R11: unexpected response actual 0x%08h expected none", rsp_rdata_o);
      end else begin
        chk(tag_q.pop_front(), rsp_rdata_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    chk("R1 pend", pend_vec_o, 32'h0);
    chk("R1 take", {31'b0, take_o}, 32'h0);
    chk("R1 rsp", {31'b0, rsp_valid_o}, 32'h0);
    bus_read(B + 32'h0, 32'h0, "R1 time lo");
    bus_read(B + 32'h4, 32'h0, "R1 time hi");
    bus_read(B + 32'h8, 32'h0, "R1 cmp lo");
    bus_read(B + 32'hC, 32'h0, "R1 cmp hi");
    // R2 step accumulation
    do_tick(5, 32'd3);
    bus_read(B + 32'h0, 32'd15, "R2 lo after 5x3");
    bus_read(B + 32'h4, 32'h0, "R2 hi unchanged");
    bus_read(B + 32'h0, 32'd15, "R2 hold without tick");
    // R3 carry
    bus_write(B + 32'h0, 32'hFFFF_FFF0);
    do_tick(1, 32'h20);
    bus_read(B + 32'h0, 32'h10, "R3 lo wraps");
    bus_read(B + 32'h4, 32'h1, "R3 hi carry");
    // R4 write replaces increment
    @(negedge clk);
    tick_i = 1'b1; tick_incr_i = 32'd5;
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = B + 32'h4; req_wdata_i = 32'h55;
    @(negedge clk);
    tick_i = 1'b0; req_valid_i = 1'b0; req_write_i = 1'b0;
    bus_read(B + 32'h0, 32'h10, "R4 lo not incremented");
    bus_read(B + 32'h4, 32'h55, "R4 hi written");
    // R5 alarm words
    bus_write(B + 32'h8, 32'h20);
    bus_write(B + 32'hC, 32'h55);
    bus_read(B + 32'h8, 32'h20, "R5 cmp lo");
    bus_read(B + 32'hC, 32'h55, "R5 cmp hi");
    chk_irq("R6 below", 1'b0);
    bus_write(B + 32'h0, 32'h20);
    chk_irq("R6 equal", 1'b0);
    do_tick(1, 32'd1);
    chk_irq("R6 above R9 R12", 1'b1);
    // R10 take gating
    int_en_i = 32'h0; status_i = 32'h8; #1;
    chk("R10 no ie take", {31'b0, take_o}, 32'h0);
    chk("R10 no ie cause", cause_o, 32'h0);
    int_en_i = 32'h80; status_i = 32'h0; #1;
    chk("R10 no gie take", {31'b0, take_o}, 32'h0);
    int_en_i = 32'h80; status_i = 32'h8; #1;
    chk("R10 take", {31'b0, take_o}, 32'h1);
    chk("R10 cause", cause_o, 32'h8000_0007);
    chk("R10 tval", tval_o, 32'h0);
    // R8 pending recomputed
    bus_write(B + 32'hC, 32'h56);
    chk_irq("R8 cleared", 1'b0);
    #1 chk("R10 no pend take", {31'b0, take_o}, 32'h0);
    // R7 zero alarm
    bus_write(B + 32'hC, 32'h0);
    chk_irq("R7 nonzero alarm pend", 1'b1);
    bus_write(B + 32'h8, 32'h0);
    chk_irq("R7 zero alarm", 1'b0);
    // R11 decode
    bus_write(B + 32'h10, 32'h123);
    bus_write(32'h2000_0000, 32'h456);
    bus_write(32'h1200_0000, 32'h789);
    bus_read(B + 32'h0, 32'h21, "R11 lo untouched");
    bus_read(B + 32'h4, 32'h55, "R11 hi untouched");
    bus_read(B + 32'h8, 32'h0, "R11 cmp lo untouched");
    bus_read(B + 32'h10, 32'h0, "R11 unmapped reads zero");
    bus_read(32'h1200_0000, 32'h0, "R11 outside window reads zero");
    repeat (3) @(negedge clk);
    chk("R11 all responses seen", exp_q.size(), 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule